// File: doc/BRIEF.md
# Programmable Countdown Watchdog Timer

The block is an 8-bit down-counting watchdog. Software reaches it through a simple synchronous register port: a one-cycle write strobe with address and data, and a one-cycle read strobe with address whose data comes back on the following cycle. The host also supplies a single-cycle tick-enable at 4.096 kHz, in the domain of the fast system clock. From that tick an internal prescaler makes three slower rates, nominally 64 Hz, 1 Hz and 1/60 Hz. A two-bit source field chooses which of the four rates drives the counter.

Software sets the enable bit, picks a source and writes a load value n. The counter then drops by one on each selected tick. At the n-th tick the count is 1 and the tick hits it: a sticky flag is raised, the interrupt output goes high and the counter stops at zero. It does not reload itself. A new load clears the flag. A nonzero value restarts the countdown and zero leaves the timer stopped. A read of the status register also clears the flag. Writes cannot touch the flag.

Register map (2-bit address): 0 = control (bit 0 enable, bits 2:1 source, other bits read 0); 1 = load on write, current count on read; 2 = status (bit 0 flag, read-only); 3 reads 0.

Top module: `cd_watchdog`

## Requirements
- R1: After reset the enable bit, source field, count, flag, irq_o and rd_data_o are all 0.
- R2: While the enable bit (control bit 0) is 0, the count does not change on any tick.
- R3: Source field control[2:1] sets the step rate. 00 steps on every tick_4k_i pulse, 01 every DIV_B pulses, 10 every DIV_C pulses and 11 every DIV_D pulses. The prescaler phase restarts at every write to address 1.
- R4: Each selected step decrements a count greater than 1 by one. A read of address 1 returns the count on rd_data_o in the cycle after the read strobe.
- R5: A step that finds the count at 1 sets the flag and irq_o and leaves the count at 0. The count then stays at 0 until the next load.
- R6: Writing a nonzero n to address 1 clears the flag and irq_o and restarts the countdown from n, so the next expiry comes n steps later.
- R7: Writing 0 to address 1 clears the flag and irq_o and stops the timer, so later ticks do not raise the flag.
- R8: Writing any value to address 2 has no effect on the flag or irq_o.
- R9: A read of address 2 returns the flag in bit 0 in the next cycle and clears the flag and irq_o.
- R10: If a status read and an expiry occur in the same cycle, the flag ends set. The read data shows the value the flag had before.
- R11: If a load write and an expiry step occur in the same cycle, the load wins: the flag ends clear and the count equals the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_4k_i | input | 1 | Single-cycle 4.096 kHz tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt level, high while the flag is set |

## Verification
The hardest cases to reach are the same-cycle collisions: a status read landing on the exact tick that expires the counter, and a reload landing on it. The stimulus gets there with the fastest source and a load of 1, so the next tick is known to expire the timer. That tick is driven in the same cycle as the read or the load. Prescaler phase reset is exercised by reloading partway through a divided period and counting the ticks until the next decrement. The bench overrides the divider parameters with small values so the three slow rates can be covered in a short run.

// File: rtl/cdw_pkg.sv
package cdw_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_CNT  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {
    SRC_FAST  = 2'b00,
    SRC_DIV_B = 2'b01,
    SRC_DIV_C = 2'b10,
    SRC_DIV_D = 2'b11
  } src_e;
endpackage

// File: rtl/cdw_prescaler.sv
module cdw_prescaler #(
  parameter int DIV_B = 64,
  parameter int DIV_C = 4096,
  parameter int DIV_D = 245760
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic [1:0] src_i,
  output logic       step_o
);
  localparam int PW = (DIV_D > 2) ? $clog2(DIV_D) : 1;
  localparam int DIVS [4] = '{1, DIV_B, DIV_C, DIV_D};

  logic [PW-1:0] lim_a [4];
  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] lim;
  logic          wrap;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_a[g] = PW'(DIVS[g] - 1);
  end

  assign lim    = lim_a[src_i];
  // >= keeps a source change mid-period from overrunning the new limit
  assign wrap   = (pcnt_q >= lim);
  assign step_o = run_i && tick_i && wrap && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
    end else if (clr_i) begin
      pcnt_q <= '0;
    end else if (run_i && tick_i) begin
      pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cdw_counter.sv
module cdw_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             rd_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             live;
  logic             expire;

  assign live   = (cnt_q != '0);
  assign expire = step_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (step_i && live) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // priority: load clears, expiry sets, read clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (load_i) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (rd_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cdw_regs.sv
module cdw_regs
  import cdw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic              en_o,
  output logic [1:0]        src_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              rd_clr_o,
  output logic [CNT_W-1:0]  rd_data_o
);
  logic             en_q;
  logic [1:0]       src_q;
  logic [CNT_W-1:0] rd_q;
  logic [CNT_W-1:0] rd_mux;
  logic             unused_ctrl_bits;

  assign unused_ctrl_bits = ^wr_data_i[CNT_W-1:3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      src_q <= SRC_FAST;
    end else if (wr_en_i && wr_addr_i == ADDR_CTRL) begin
      en_q  <= wr_data_i[0];
      src_q <= wr_data_i[2:1];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr_i)
      ADDR_CTRL: rd_mux = {{(CNT_W-3){1'b0}}, src_q, en_q};
      ADDR_CNT:  rd_mux = cnt_i;
      ADDR_STAT: rd_mux = {{(CNT_W-1){1'b0}}, flag_i};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= rd_mux;
    end
  end

  assign en_o       = en_q;
  assign src_o      = src_q;
  assign load_o     = wr_en_i && (wr_addr_i == ADDR_CNT);
  assign load_val_o = wr_data_i;
  assign rd_clr_o   = rd_en_i && (rd_addr_i == ADDR_STAT);
  assign rd_data_o  = rd_q;
endmodule

// File: rtl/cd_watchdog.sv
module cd_watchdog
  import cdw_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_B = 64,
  parameter int DIV_C = 4096,
  parameter int DIV_D = 245760
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_4k_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              rd_en_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              irq_o
);
  logic             en_w;
  logic [1:0]       src_w;
  logic             load_w;
  logic [CNT_W-1:0] load_val_w;
  logic             rd_clr_w;
  logic             step_w;
  logic [CNT_W-1:0] cnt_w;
  logic             flag_w;

  cdw_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .cnt_i      (cnt_w),
    .flag_i     (flag_w),
    .en_o       (en_w),
    .src_o      (src_w),
    .load_o     (load_w),
    .load_val_o (load_val_w),
    .rd_clr_o   (rd_clr_w),
    .rd_data_o  (rd_data_o)
  );

  cdw_prescaler #(.DIV_B(DIV_B), .DIV_C(DIV_C), .DIV_D(DIV_D)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_4k_i),
    .run_i  (en_w),
    .clr_i  (load_w),
    .src_i  (src_w),
    .step_o (step_w)
  );

  cdw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .step_i     (step_w),
    .rd_clr_i   (rd_clr_w),
    .cnt_o      (cnt_w),
    .flag_o     (flag_w)
  );

  assign irq_o = flag_w;
endmodule

// File: rtl/cdw_checker.sv
module cdw_checker
  import cdw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [REG_AW-1:0] wr_addr_i,
  input logic              rd_en_i,
  input logic [REG_AW-1:0] rd_addr_i,
  input logic              irq_o,
  input logic              en,
  input logic              step,
  input logic [CNT_W-1:0]  cnt
);
  logic ld, rdst, hit;
  assign ld   = wr_en_i && wr_addr_i == ADDR_CNT;
  assign rdst = rd_en_i && rd_addr_i == ADDR_STAT;
  assign hit  = step && cnt == CNT_W'(1);

  assert_hold_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !ld) |=> $stable(cnt));

  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt > CNT_W'(1) && !ld) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_expire_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !ld) |=> (irq_o && cnt == '0));

  assert_stay_stopped_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !ld) |=> (cnt == '0));

  assert_load_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> !irq_o);

  assert_stat_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_STAT && !hit && !rdst) |=> (irq_o == $past(irq_o)));

  assert_read_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdst && !hit && !ld) |=> !irq_o);

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdst && hit && !ld) |=> irq_o);
endmodule

bind cd_watchdog cdw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .irq_o     (irq_o),
  .en        (en_w),
  .step      (step_w),
  .cnt       (cnt_w)
);

// File: tb/cd_watchdog_test.sv
module cd_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int DB = 4, DC = 8, DD = 16;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic       rd_en = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       irq;

  int errors = 0, checks = 0;
  bit done = 0;
  logic       rd_seen = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cd_watchdog #(.DIV_B(DB), .DIV_C(DC), .DIV_D(DD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_4k_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: read data is valid at the negedge after the strobe's posedge
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data %h", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic op(input bit t, input bit w, input logic [1:0] wa, input logic [7:0] wd,
                    input bit r, input logic [1:0] ra, input logic [7:0] re, input string tg);
    tick = t; wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
    if (r) begin exp_q.push_back(re); tag_q.push_back(tg); end
    @(negedge clk);
    tick = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    op(0, 1, a, d, 0, 0, 0, "");
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tg);
    op(0, 0, 0, 0, 1, a, e, tg);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) op(1, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic chk_irq(input logic e, input string tg);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tg, irq, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk_irq(0, "R1 irq after reset");
    checks++;
    if (rd_data !== 8'h00) begin errors++; $display("FAIL R1 rd_data=%h expected 00", rd_data); end
    rst_n = 1;
    @(negedge clk);
    rd(0, 8'h00, "R1 ctrl reset");
    rd(1, 8'h00, "R1 count reset");
    rd(2, 8'h00, "R1 flag reset");

    // fast source countdown
    wr(0, 8'h01);
    rd(0, 8'h01, "R1 ctrl readback");
    wr(1, 8'd3);
    rd(1, 8'd3, "R4 loaded count");
    ticks(1); rd(1, 8'd2, "R4 decrement");
    ticks(1); rd(1, 8'd1, "R4 decrement to 1"); chk_irq(0, "R5 no early expiry");
    ticks(1); chk_irq(1, "R5 expiry");
    rd(1, 8'd0, "R5 count zero after expiry");
    ticks(3); rd(1, 8'd0, "R5 no auto reload");

    // status writes ignored, read clears
    wr(2, 8'h00); chk_irq(1, "R8 write 0 to status");
    wr(2, 8'hFF); chk_irq(1, "R8 write 1 to status");
    rd(2, 8'h01, "R9 status shows flag");
    chk_irq(0, "R9 read clears");
    rd(2, 8'h00, "R9 flag cleared");

    // disabled holds
    wr(0, 8'h00);
    wr(1, 8'd5);
    ticks(3); rd(1, 8'd5, "R2 hold while disabled");

    // source 01
    wr(0, 8'h03);
    wr(1, 8'd2);
    ticks(DB - 1); rd(1, 8'd2, "R3 div B before step");
    ticks(1); rd(1, 8'd1, "R3 div B step");
    ticks(DB - 1); chk_irq(0, "R3 div B no early expiry");
    ticks(1); chk_irq(1, "R3 div B expiry");
    wr(1, 8'd2); chk_irq(0, "R6 reload clears flag");
    ticks(2 * DB); chk_irq(1, "R6 restart expiry after n steps");

    // source 10
    wr(0, 8'h05);
    wr(1, 8'd1);
    ticks(DC - 1); chk_irq(0, "R3 div C before expiry");
    ticks(1); chk_irq(1, "R3 div C expiry");

    // source 11
    wr(0, 8'h07);
    wr(1, 8'd1);
    ticks(DD - 1); chk_irq(0, "R3 div D before expiry");
    ticks(1); chk_irq(1, "R3 div D expiry");

    // zero load stops
    wr(1, 8'd0); chk_irq(0, "R7 zero load clears");
    ticks(DD * 2); chk_irq(0, "R7 stopped no expiry");
    rd(1, 8'd0, "R7 count stays zero");

    // prescaler phase reset on load
    wr(0, 8'h03);
    wr(1, 8'd5);
    ticks(2);
    wr(1, 8'd5);
    ticks(DB - 1); rd(1, 8'd5, "R3 phase reset holds");
    ticks(1); rd(1, 8'd4, "R3 phase reset step");

    // read and expiry same cycle
    wr(0, 8'h01);
    wr(1, 8'd1);
    op(1, 0, 0, 0, 1, 2, 8'h00, "R10 read data before set");
    chk_irq(1, "R10 set wins over read");
    rd(2, 8'h01, "R10 flag kept");
    chk_irq(0, "R9 cleared after later read");

    // load and expiry same cycle
    wr(1, 8'd1);
    op(1, 1, 1, 8'd4, 0, 0, 0, "");
    chk_irq(0, "R11 load wins over expiry");
    rd(1, 8'd4, "R11 count is loaded value");

    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin errors++; $display("FAIL reads pending=%0d expected 0", exp_q.size()); end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule